// File: doc/BRIEF.md
# Multi-Master Crossbar with Per-Slave Arbitration

This block joins six bus masters to five memory or peripheral slaves through a full crossbar. Each master issues single-beat transfers with a valid flag, an address, a write flag and write data. It holds all of them steady until it sees ready, and it takes read data in that same cycle. The top address bits select the slave. Transfers that target different slaves pass through side by side, so all five slaves can be busy in one cycle.

Every slave has its own arbiter and its own policy: fixed priority, programmable priority, round-robin, or parking on a chosen default master. The arbiter keeps a registered grant holder. A holder that asks for the slave is connected at once. Any other master reaches the slave one cycle after the arbiter picks it. Once a transfer is on the slave port, the grant stays until the slave accepts it. Policy settings come in on static configuration inputs. Each arbiter copies them only while its slave is idle.

Top module: `xbar_switch`

## Requirements
- R1: A master's address `a` (16 bits) selects slave `(a*5) >> 16`, which divides the space into five equal regions. The selected slave sees the address unchanged.
- R2: Masters that target different slaves are served in the same cycle, up to one master on each of the five slaves.
- R3: While a slave's valid is high and its ready is low, the master connected to that slave does not change.
- R4: In mode 0 (fixed), the requesting master with the lowest index wins.
- R5: In mode 1 (programmable), each master has a 3-bit priority for each slave at `arb_prio[(s*6+m)*3 +: 3]`. The larger value wins, and a tie goes to the lower index.
- R6: In mode 2 (round-robin), the search starts at the master after the one most recently picked on that slave and wraps around.
- R7: In mode 3 (parking), a slave with no requester hands its grant to the master in `arb_park[s*3 +: 3]`. That master is then served in the same cycle it first asks. Arbitration in this mode follows fixed priority. In modes 0 to 2, an idle slave keeps its last grant holder.
- R8: If an idle slave's grant holder requests it, the request reaches the slave in the same cycle. Otherwise the master picked from the requesters reaches the slave one cycle later. After a completing transfer, the other requesters are picked ahead of the master that just finished.
- R9: `arb_mode[s*2 +: 2]`, `arb_park` and `arb_prio` for slave `s` are copied only on cycles when that slave's valid is low. A change made while the slave is busy first steers arbitration one cycle after the slave goes idle.
- R10: A master's ready is high only when its own request is on its target slave and that slave is ready. The master's read data comes from the target slave. The slave's address, write flag and write data come from the connected master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_valid | input | 6 | Request valid, one bit per master |
| mst_addr | input | 96 | Addresses, 16 bits per master |
| mst_write | input | 6 | Write flag per master |
| mst_wdata | input | 192 | Write data, 32 bits per master |
| mst_rdata | output | 192 | Read data, 32 bits per master |
| mst_ready | output | 6 | Transfer accepted, per master |
| slv_valid | output | 5 | Request valid per slave |
| slv_addr | output | 80 | Address per slave |
| slv_write | output | 5 | Write flag per slave |
| slv_wdata | output | 160 | Write data per slave |
| slv_rdata | input | 160 | Read data per slave |
| slv_ready | input | 5 | Slave accepts the presented transfer |
| arb_mode | input | 10 | Policy per slave: 0 fixed, 1 programmable, 2 round-robin, 3 parking |
| arb_prio | input | 90 | 3-bit priority per slave and master |
| arb_park | input | 15 | Parking master index per slave |

## Verification
The assertions assume that a master holds its valid, address and write data steady until it sees ready, and that park indices stay below six. The bench's masters keep to this: none changes its request before it is accepted or explicitly withdrawn. Withdrawing happens only on a stalled slave or before any grant.

The bench also sets configuration only while the slave concerned is idle, except in the test that covers R9. In that test it changes the policy in mid-transfer on purpose and checks that the old policy still decides the first idle cycle.

All 63 request masks are swept under each policy on one slave that is held stalled. Expected winners are derived arithmetically from the grant holder and the last pick, both tracked in the bench.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
// Shared types for the crossbar: the per-slave arbitration policy code.
package xbar_pkg;
    typedef enum logic [1:0] {
        ARB_FIXED  = 2'd0,
        ARB_PRIO   = 2'd1,
        ARB_RROBIN = 2'd2,
        ARB_PARK   = 2'd3
    } arb_mode_e;
endpackage

// File: rtl/xbar_addr_dec.sv
`timescale 1ns/1ps
// Address decoder: maps one master address onto one of N_SLV equal regions.
// Assumes N_SLV >= 2; the region index is (addr * N_SLV) >> AW.
module xbar_addr_dec #(
    parameter int AW    = 16,
    parameter int N_SLV = 5,
    parameter int SW    = $clog2(N_SLV)
) (
    input  logic [AW-1:0] addr,
    output logic [SW-1:0] tgt
);
    localparam int XW = AW + SW;

    logic [XW-1:0] scaled;

    // Scale the address by the slave count; the top SW bits are the region.
    always_comb begin
        scaled = {{SW{1'b0}}, addr} * XW'(N_SLV);
        tgt    = SW'(scaled >> AW);
    end
endmodule

// File: rtl/xbar_slave_arb.sv
`timescale 1ns/1ps
// Per-slave arbiter: holds the grant owner for one slave and picks the next.
// Assumes each master keeps its request steady until served.
// Config is copied only while the slave port carries no request.
module xbar_slave_arb
    import xbar_pkg::*;
#(
    parameter int N_MST  = 6,
    parameter int PRIO_W = 3,
    parameter int IW     = $clog2(N_MST)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_MST-1:0]        req,
    input  logic                    slv_ready,
    input  logic [1:0]              cfg_mode,
    input  logic [N_MST*PRIO_W-1:0] cfg_prio,
    input  logic [IW-1:0]           cfg_park,
    output logic [IW-1:0]           owner,
    output logic                    slv_valid
);
    arb_mode_e                 mode_q;
    logic [N_MST*PRIO_W-1:0]   prio_q;
    logic [IW-1:0]             park_q;
    logic [IW-1:0]             owner_q;
    logic [IW-1:0]             last_q;
    logic [IW-1:0]             owner_d;
    logic [IW-1:0]             win;
    logic [N_MST-1:0]          cand;
    logic                      busy;
    logic                      done;
    logic                      any;

    // Slave-side handshake as seen through the current owner.
    always_comb begin
        slv_valid = req[owner_q];
        done      = slv_valid & slv_ready;
        busy      = slv_valid & ~slv_ready;
        cand      = done ? (req & ~(N_MST'(1) << owner_q)) : req;
        any       = |cand;
    end

    // Winner among the candidates under the current policy.
    always_comb begin
        logic             found;
        logic [PRIO_W-1:0] bestp;
        found = 1'b0;
        bestp = '0;
        win   = '0;
        case (mode_q)
            ARB_PRIO: begin
                for (int m = 0; m < N_MST; m++) begin
                    if (cand[m] && (!found || prio_q[m*PRIO_W +: PRIO_W] > bestp)) begin
                        found = 1'b1;
                        bestp = prio_q[m*PRIO_W +: PRIO_W];
                        win   = IW'(m);
                    end
                end
            end
            ARB_RROBIN: begin
                for (int k = 1; k <= N_MST; k++) begin
                    int idx;
                    idx = (int'(last_q) + k) % N_MST;
                    if (!found && cand[idx]) begin
                        found = 1'b1;
                        win   = IW'(idx);
                    end
                end
            end
            default: begin
                for (int m = N_MST - 1; m >= 0; m--) begin
                    if (cand[m]) win = IW'(m);
                end
            end
        endcase
    end

    // Next owner: hold while busy, pick when contended, else park or keep.
    always_comb begin
        if (busy)
            owner_d = owner_q;
        else if (any)
            owner_d = win;
        else if (!done && mode_q == ARB_PARK && int'(park_q) < N_MST)
            owner_d = park_q;
        else
            owner_d = owner_q;
    end

    // Owner and last-pick registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= '0;
            last_q  <= '0;
        end else begin
            owner_q <= owner_d;
            if (!busy && any) last_q <= win;
        end
    end

    // Config shadow, loaded only while the slave is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= ARB_FIXED;
            prio_q <= '0;
            park_q <= '0;
        end else if (!slv_valid) begin
            mode_q <= arb_mode_e'(cfg_mode);
            prio_q <= cfg_prio;
            park_q <= cfg_park;
        end
    end

    assign owner = owner_q;

    p_grant_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(owner_q));
    p_owner_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(owner_q) < N_MST);
    p_fixed_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mode_q == ARB_FIXED && cand[0]) |=> owner_q == '0);
    p_rr_moves_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mode_q == ARB_RROBIN && $countones(cand) > 1) |=> owner_q != $past(last_q));
    p_park_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ARB_PARK && req == '0 && int'(park_q) < N_MST) |=> owner_q == $past(park_q));
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        slv_valid |=> (mode_q == $past(mode_q) && park_q == $past(park_q)));
endmodule

// File: rtl/xbar_switch.sv
`timescale 1ns/1ps
// Crossbar switch: N_MST masters to N_SLV slaves, one arbiter per slave.
// Assumes single-beat transfers held by the master until ready.
// Read data is valid alongside ready.
module xbar_switch #(
    parameter int N_MST  = 6,
    parameter int N_SLV  = 5,
    parameter int AW     = 16,
    parameter int DW     = 32,
    parameter int PRIO_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_MST-1:0]              mst_valid,
    input  logic [N_MST*AW-1:0]           mst_addr,
    input  logic [N_MST-1:0]              mst_write,
    input  logic [N_MST*DW-1:0]           mst_wdata,
    output logic [N_MST*DW-1:0]           mst_rdata,
    output logic [N_MST-1:0]              mst_ready,
    output logic [N_SLV-1:0]              slv_valid,
    output logic [N_SLV*AW-1:0]           slv_addr,
    output logic [N_SLV-1:0]              slv_write,
    output logic [N_SLV*DW-1:0]           slv_wdata,
    input  logic [N_SLV*DW-1:0]           slv_rdata,
    input  logic [N_SLV-1:0]              slv_ready,
    input  logic [N_SLV*2-1:0]            arb_mode,
    input  logic [N_SLV*N_MST*PRIO_W-1:0] arb_prio,
    input  logic [N_SLV*$clog2(N_MST)-1:0] arb_park
);
    localparam int IW = $clog2(N_MST);
    localparam int SW = $clog2(N_SLV);

    logic [SW-1:0]    tgt     [N_MST];
    logic [IW-1:0]    own     [N_SLV];
    logic [N_MST-1:0] req_mat [N_SLV];

    genvar gm, gs;

    // One address decoder per master.
    generate
        for (gm = 0; gm < N_MST; gm++) begin : g_dec
            xbar_addr_dec #(.AW(AW), .N_SLV(N_SLV), .SW(SW)) dec_i (
                .addr (mst_addr[gm*AW +: AW]),
                .tgt  (tgt[gm])
            );

            p_tgt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
                mst_valid[gm] |-> int'(tgt[gm]) < N_SLV);
            p_ready_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
                mst_ready[gm] |-> mst_valid[gm]);
        end
    endgenerate

    // Request matrix: master m asks slave s when valid and decoded there.
    always_comb begin
        for (int s = 0; s < N_SLV; s++)
            for (int m = 0; m < N_MST; m++)
                req_mat[s][m] = mst_valid[m] && (tgt[m] == SW'(s));
    end

    // One arbiter per slave.
    generate
        for (gs = 0; gs < N_SLV; gs++) begin : g_arb
            xbar_slave_arb #(.N_MST(N_MST), .PRIO_W(PRIO_W), .IW(IW)) arb_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .req       (req_mat[gs]),
                .slv_ready (slv_ready[gs]),
                .cfg_mode  (arb_mode[gs*2 +: 2]),
                .cfg_prio  (arb_prio[gs*N_MST*PRIO_W +: N_MST*PRIO_W]),
                .cfg_park  (arb_park[gs*IW +: IW]),
                .owner     (own[gs]),
                .slv_valid (slv_valid[gs])
            );

            p_slave_from_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
                slv_valid[gs] |-> (mst_valid[own[gs]] && tgt[own[gs]] == SW'(gs)));
        end
    endgenerate

    // Slave-side mux: forward the owner's request fields.
    always_comb begin
        for (int s = 0; s < N_SLV; s++) begin
            slv_addr[s*AW +: AW]  = mst_addr[int'(own[s])*AW +: AW];
            slv_write[s]          = mst_write[own[s]];
            slv_wdata[s*DW +: DW] = mst_wdata[int'(own[s])*DW +: DW];
        end
    end

    // Master-side return: ready and read data from the decoded slave.
    always_comb begin
        for (int m = 0; m < N_MST; m++) begin
            mst_ready[m] = mst_valid[m] && slv_valid[tgt[m]] && slv_ready[tgt[m]]
                           && (own[tgt[m]] == IW'(m));
            mst_rdata[m*DW +: DW] = slv_rdata[int'(tgt[m])*DW +: DW];
        end
    end
endmodule

// File: tb/xbar_switch_tb.sv
`timescale 1ns/1ps
// Bench: sweeps request masks per policy and walks the routing corner cases.
module xbar_switch_tb_top;
    localparam int NM = 6, NS = 5, AW = 16, DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [NM-1:0]      m_valid, m_write;
    logic [AW-1:0]      addr_a [NM];
    logic [NM*AW-1:0]   mst_addr;
    logic [NM*DW-1:0]   mst_wdata, mst_rdata;
    logic [NM-1:0]      mst_ready;
    logic [NS-1:0]      slv_valid, slv_write, slv_ready, en;
    logic [NS*AW-1:0]   slv_addr;
    logic [NS*DW-1:0]   slv_wdata, slv_rdata;
    logic [1:0]         mode_a [NS];
    logic [2:0]         park_a [NS];
    int                 prio_tab [NM];
    logic [NS*2-1:0]    arb_mode;
    logic [NS*NM*3-1:0] arb_prio;
    logic [NS*3-1:0]    arb_park;

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 1'b0;
    int exp_owner = 0, exp_last = 0;

    // Pack bench-side arrays onto the DUT buses.
    always_comb begin
        for (int m = 0; m < NM; m++) begin
            mst_addr[m*AW +: AW]  = addr_a[m];
            mst_wdata[m*DW +: DW] = {24'hA5A5A5, 8'(m)};
        end
        arb_prio = '0;
        for (int m = 0; m < NM; m++) arb_prio[(2*NM+m)*3 +: 3] = 3'(prio_tab[m]);
        for (int s = 0; s < NS; s++) begin
            arb_mode[s*2 +: 2]    = mode_a[s];
            arb_park[s*3 +: 3]    = park_a[s];
            slv_rdata[s*DW +: DW] = {8'h5A, 8'(s), slv_addr[s*AW +: AW]};
        end
        slv_ready = slv_valid & en;
    end

    xbar_switch dut_i (
        .clk(clk), .rst_n(rst_n),
        .mst_valid(m_valid), .mst_addr(mst_addr), .mst_write(m_write),
        .mst_wdata(mst_wdata), .mst_rdata(mst_rdata), .mst_ready(mst_ready),
        .slv_valid(slv_valid), .slv_addr(slv_addr), .slv_write(slv_write),
        .slv_wdata(slv_wdata), .slv_rdata(slv_rdata), .slv_ready(slv_ready),
        .arb_mode(arb_mode), .arb_prio(arb_prio), .arb_park(arb_park)
    );

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int region(int a);
        return (a * 5) >> 16;
    endfunction

    function automatic int base(int s);
        return s * 13108 + 5;
    endfunction

    function automatic int widx(int s);
        return int'(slv_wdata[s*DW +: 8]);
    endfunction

    function automatic int exp_pick(int mask, int mode, int last);
        int w = -1;
        if (mode == 1) begin
            for (int m = 0; m < NM; m++)
                if (mask[m] && (w < 0 || prio_tab[m] > prio_tab[w])) w = m;
        end else if (mode == 2) begin
            for (int k = 1; k <= NM; k++)
                if (w < 0 && mask[(last + k) % NM]) w = (last + k) % NM;
        end else begin
            for (int m = NM - 1; m >= 0; m--) if (mask[m]) w = m;
        end
        return w;
    endfunction

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_req(int m, int s);
        m_valid[m] = 1'b1;
        addr_a[m]  = 16'(base(s));
    endtask

    // One arbitration trial on slave 2 (held stalled) for a request mask.
    task automatic trial(int mask, int mode, string tag);
        int win;
        @(negedge clk);
        for (int m = 0; m < NM; m++) if (mask[m]) set_req(m, 2);
        #1;
        if (mask[exp_owner]) begin
            chk(slv_valid[2] && widx(2) == exp_owner, "R8 holder served at once", widx(2), exp_owner);
            win = exp_owner;
        end else begin
            chk(!slv_valid[2], "R8 no same-cycle grant", slv_valid[2], 0);
            win = exp_pick(mask, mode, exp_last);
            exp_last = win;
        end
        @(negedge clk); #1;
        chk(slv_valid[2] && widx(2) == win, tag, widx(2), win);
        m_valid = '0;
        exp_owner = (mode == 3) ? int'(park_a[2]) : win;
        @(negedge clk);
    endtask

    task automatic set_mode(int s, int mode, int park);
        @(negedge clk);
        mode_a[s] = 2'(mode);
        park_a[s] = 3'(park);
        idle(2);
    endtask

    task automatic sweep(int a, bit wr);
        int r;
        @(negedge clk);
        m_valid[0] = 1'b1; addr_a[0] = 16'(a); m_write[0] = wr;
        #1;
        if (!mst_ready[0]) begin @(negedge clk); #1; end
        r = region(a);
        chk(mst_ready[0] && slv_valid[r], "R1 region select", slv_valid, 1 << r);
        chk(slv_addr[r*AW +: AW] == 16'(a) && slv_write[r] == wr, "R1 address passed", slv_addr[r*AW +: AW], a);
        chk(mst_rdata[0 +: DW] == {8'h5A, 8'(r), 16'(a)}, "R10 read data route", mst_rdata[0 +: DW], {8'h5A, 8'(r), 16'(a)});
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_valid = '0; m_write = '0; en = '1;
        for (int m = 0; m < NM; m++) begin addr_a[m] = '0; prio_tab[m] = 0; end
        for (int s = 0; s < NS; s++) begin mode_a[s] = 2'd0; park_a[s] = 3'd0; end
        idle(3);
        #1;
        chk(slv_valid == '0 && mst_ready == '0, "reset outputs idle", {slv_valid, mst_ready}, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(1);

        // R4 R5 R6 R7: all masks under every policy on stalled slave 2.
        en[2] = 1'b0;
        for (int mk = 1; mk < 64; mk++) trial(mk, 0, "R4 fixed winner");
        prio_tab = '{3, 5, 5, 1, 7, 0};
        set_mode(2, 1, 0);
        for (int mk = 1; mk < 64; mk++) trial(mk, 1, "R5 priority winner");
        prio_tab = '{2, 2, 2, 2, 2, 2};
        set_mode(2, 1, 0);
        for (int mk = 1; mk < 64; mk++) trial(mk, 1, "R5 tie to lower index");
        set_mode(2, 2, 0);
        for (int mk = 1; mk < 64; mk++) trial(mk, 2, "R6 round-robin winner");
        set_mode(2, 3, 3);
        exp_owner = 3;
        for (int mk = 1; mk < 64; mk++) trial(mk, 3, "R7 parking-mode winner");
        set_mode(2, 0, 0);
        en[2] = 1'b1;

        // R1 R10: address sweep from master 0 with boundaries.
        for (int k = 0; k < 64; k++) sweep((k * 1021 + 7) & 16'hFFFF, k[0]);
        for (int b = 1; b < 5; b++) begin
            sweep((b * 65536 + 4) / 5 - 1, 1'b0);
            sweep((b * 65536 + 4) / 5, 1'b1);
        end
        @(negedge clk); m_valid = '0;
        idle(1);

        // R2: five masters to five slaves at once.
        @(negedge clk);
        for (int m = 1; m < NM; m++) set_req(m, m - 1);
        @(negedge clk); #1;
        chk(slv_valid == 5'h1F, "R2 all slaves active", slv_valid, 5'h1F);
        chk(mst_ready[5:1] == 5'h1F, "R2 all masters ready", mst_ready[5:1], 5'h1F);
        for (int s = 0; s < NS; s++)
            chk(widx(s) == s + 1, "R10 write data from owner", widx(s), s + 1);
        m_valid = '0;
        idle(1);

        // R3: grant held on stalled slave 3 against a higher-priority master.
        en[3] = 1'b0;
        @(negedge clk); set_req(3, 3);
        @(negedge clk); #1;
        chk(slv_valid[3] && widx(3) == 3, "R8 granted next cycle", widx(3), 3);
        set_req(0, 3);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            chk(widx(3) == 3 && !mst_ready[0], "R3 grant held while stalled", widx(3), 3);
        end
        en[3] = 1'b1; #1;
        chk(mst_ready[3], "R10 ready to owner", mst_ready[3], 1);
        @(negedge clk); m_valid[3] = 1'b0; #1;
        chk(mst_ready[0] && widx(3) == 0, "R8 waiter takes over after completion", widx(3), 0);
        @(negedge clk); m_valid = '0;
        idle(1);

        // R7 R8: parking on slave 1 at master 4.
        set_mode(1, 3, 4);
        @(negedge clk); set_req(4, 1); #1;
        chk(mst_ready[4], "R7 parked master zero-wait", mst_ready[4], 1);
        @(negedge clk); m_valid = '0; set_req(1, 1); #1;
        chk(!mst_ready[1], "R8 arbitration cycle", mst_ready[1], 0);
        @(negedge clk); #1;
        chk(mst_ready[1], "R8 served after one cycle", mst_ready[1], 1);
        @(negedge clk); m_valid = '0;
        idle(2);
        set_req(4, 1); #1;
        chk(mst_ready[4], "R7 grant returns to park", mst_ready[4], 1);
        @(negedge clk); m_valid = '0;
        set_mode(1, 0, 0);

        // R9: config changed while slave 4 is busy.
        set_mode(4, 3, 2);
        en[4] = 1'b0;
        @(negedge clk); set_req(1, 4);
        @(negedge clk); #1;
        chk(slv_valid[4] && widx(4) == 1, "R9 busy setup", widx(4), 1);
        mode_a[4] = 2'd0;
        idle(3);
        en[4] = 1'b1; #1;
        chk(mst_ready[1], "R9 busy transfer completes", mst_ready[1], 1);
        @(negedge clk); m_valid = '0;
        @(negedge clk); set_req(2, 4); #1;
        chk(mst_ready[2], "R9 old policy decides first idle cycle", mst_ready[2], 1);
        @(negedge clk); m_valid = '0;
        @(negedge clk); set_req(0, 4); #1;
        chk(!mst_ready[0], "R9 arbitration under new policy", mst_ready[0], 0);
        @(negedge clk); #1;
        chk(mst_ready[0], "R9 master 0 served", mst_ready[0], 1);
        @(negedge clk); m_valid = '0;
        idle(2);
        set_req(2, 4); #1;
        chk(!mst_ready[2], "R9 parking no longer applied", mst_ready[2], 0);
        @(negedge clk); m_valid = '0;
        idle(2);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule